// File: doc/BRIEF.md
# Completion Queue Flush Watchdog

This block limits how long completion entries may wait in a small staging FIFO before the DMA engine writes them out to the completion queue in host memory. The host programs a 16-bit interval value. A fixed divide-by-256 prescaler on the bus clock drives a down-counter that is loaded with that value. When the counter runs out while the FIFO holds at least one entry, the block sends the DMA engine a one-cycle flush request. Every completion-queue write by the DMA engine restarts the interval, so the request fires only when no write has happened for the programmed time.

The timer runs only while the FIFO enable input is high. An interval value of zero is not a legal setting. If the enable is seen high while the value is zero, the block raises a sticky flag and the timer does not run. When the host changes the interval while the timer is running, the new value is used from the next reload onwards.

Top module: `dq_flush_timer`

## Requirements
- R1: After reset the interval register reads 0. A write on the configuration port loads all 16 bits, and the new value appears on `cfg_rd_data` one cycle later.
- R2: Call the clock edge that starts or reloads the timer E0, and the interval value N. If nothing else intervenes, `flush_req` is high during the cycle that follows edge E0 + 256·N.
- R3: While `fifo_en` is low, `flush_req` stays low and the timer does not advance. When `fifo_en` rises again, a full new interval starts.
- R4: If the interval expires while `fifo_not_empty` is low, the timer reloads and no flush is requested. The next expiry falls a full interval later.
- R5: `flush_req` is a pulse one cycle wide. The timer reloads at the edge where it expires, so while the FIFO stays non-empty the flushes repeat every 256·N cycles.
- R6: If `fifo_en` is sampled high while the interval value is 0, `cfg_illegal` goes high and stays high until reset. While the value is 0, no flush is ever requested.
- R7: A `dq_write` strobe while the timer runs reloads both the counter and the prescaler. If the strobe falls on the expiry edge, it takes priority and no flush is issued.
- R8: A write to the interval register while the timer runs does not change the interval in progress. The new value is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Strobe that writes the interval register |
| cfg_wr_data | input | 16 | New interval value |
| cfg_rd_data | output | 16 | Current interval register contents |
| fifo_en | input | 1 | Staging FIFO enable; the timer runs only while this is high |
| dq_write | input | 1 | Strobe: the DMA engine wrote to the completion queue |
| fifo_not_empty | input | 1 | The staging FIFO holds at least one entry |
| flush_req | output | 1 | One-cycle request to the DMA engine to flush the FIFO |
| cfg_illegal | output | 1 | Sticky flag: the FIFO was enabled while the interval was 0 |

## Verification
The reload edge is the first edge that samples an enable, a strobe or an expiry. The flush is due in the cycle after edge E0 + 256·N, because the prescaler wraps on its 256th edge and the request passes through one register. The register readback and the illegal flag are due one cycle after the edge that samples their cause. The bench keeps a cycle count and drives every input at a falling edge, so it knows the number of the edge that will sample the stimulus. It places the expected flush cycle in a scoreboard queue. A monitor compares `flush_req` at each falling edge and reports a flush that arrives early, late, twice or without a matching entry.

// File: rtl/dqft_pkg.sv
package dqft_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned PRE_W = 8;

  typedef enum logic [1:0] {
    RLD_NONE  = 2'd0,
    RLD_START = 2'd1,
    RLD_WRITE = 2'd2,
    RLD_EXPIRE = 2'd3
  } reload_cause_e;

  // Cycles from a reload edge to the expiry edge for an interval value.
  function automatic longint unsigned expiry_cycles(input logic [CNT_W-1:0] ival,
                                                    input int unsigned pre_w);
    expiry_cycles = longint'(ival) << pre_w;
  endfunction

  // Next value of the down-counter for one prescaler tick.
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] cur);
    count_step = cur - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  // Last tick of an interval: the count is about to leave one.
  function automatic logic count_at_end(input logic [CNT_W-1:0] cur);
    count_at_end = (cur == {{(CNT_W-1){1'b0}}, 1'b1});
  endfunction
endpackage

// File: rtl/dqft_cfg_reg.sv
module dqft_cfg_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         fifo_en,
  output logic [W-1:0] ival,
  output logic         ival_zero,
  output logic         illegal
);
  logic [W-1:0] ival_q;
  logic         illegal_q;

  assign ival      = ival_q;
  assign ival_zero = (ival_q == '0);
  assign illegal   = illegal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (wr_en) ival_q <= wr_data;
      if (fifo_en && ival_zero) illegal_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dqft_prescaler.sv
module dqft_prescaler #(
  parameter int unsigned PW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam logic [PW-1:0] LAST = '1;
  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)            pre_q <= '0;
    else if (clear || !run) pre_q <= '0;
    else                   pre_q <= pre_q + {{(PW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/dqft_downcounter.sv
module dqft_downcounter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         at_end
);
  import dqft_pkg::*;
  logic [W-1:0] cnt_q;

  assign at_end = count_at_end(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= count_step(cnt_q);
  end
endmodule

// File: rtl/dq_flush_timer.sv
module dq_flush_timer #(
  parameter int unsigned CNT_W = dqft_pkg::CNT_W,
  parameter int unsigned PRE_W = dqft_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CNT_W-1:0] cfg_wr_data,
  output logic [CNT_W-1:0] cfg_rd_data,
  input  logic             fifo_en,
  input  logic             dq_write,
  input  logic             fifo_not_empty,
  output logic             flush_req,
  output logic             cfg_illegal
);
  import dqft_pkg::*;

  logic [CNT_W-1:0] ival;
  logic             ival_zero;
  logic             active;
  logic             running_q;
  logic             start_evt;
  logic             write_evt;
  logic             tick_evt;
  logic             at_end;
  logic             expire_evt;
  logic             reload_evt;
  logic             flush_d;
  logic             flush_q;
  reload_cause_e    cause;

  dqft_cfg_reg #(.W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .fifo_en(fifo_en), .ival(ival), .ival_zero(ival_zero), .illegal(cfg_illegal)
  );

  // The timer runs only with the FIFO enabled and a legal interval.
  assign active     = fifo_en && !ival_zero;
  assign start_evt  = active && !running_q;
  assign write_evt  = active && running_q && dq_write;
  assign expire_evt = active && running_q && tick_evt && at_end && !dq_write;
  assign reload_evt = start_evt || write_evt || expire_evt;
  assign flush_d    = expire_evt && fifo_not_empty;

  always_comb begin
    if (start_evt)       cause = RLD_START;
    else if (write_evt)  cause = RLD_WRITE;
    else if (expire_evt) cause = RLD_EXPIRE;
    else                 cause = RLD_NONE;
  end

  dqft_prescaler #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(active && running_q),
    .clear(reload_evt), .tick(tick_evt)
  );

  dqft_downcounter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(reload_evt), .load_val(ival),
    .tick(tick_evt), .at_end(at_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      running_q <= active;
      flush_q   <= flush_d;
    end
  end

  assign flush_req   = flush_q;
  assign cfg_rd_data = ival;
endmodule

module dq_flush_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [CNT_W-1:0] cfg_wr_data,
  input logic [CNT_W-1:0] cfg_rd_data,
  input logic             fifo_en,
  input logic             dq_write,
  input logic             fifo_not_empty,
  input logic             flush_req,
  input logic             cfg_illegal,
  input logic             tick_evt
);
  a_r1_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));
  a_r2_flush_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(tick_evt));
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !flush_req);
  a_r4_flush_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(fifo_not_empty));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);
  a_r6_illegal_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && cfg_rd_data == '0) |=> cfg_illegal);
  a_r6_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |=> cfg_illegal);
  a_r7_write_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    dq_write |=> !flush_req);
endmodule

bind dq_flush_timer dq_flush_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .cfg_rd_data(cfg_rd_data), .fifo_en(fifo_en), .dq_write(dq_write),
  .fifo_not_empty(fifo_not_empty), .flush_req(flush_req),
  .cfg_illegal(cfg_illegal), .tick_evt(tick_evt)
);

// File: tb/dq_flush_timer_bench.sv
module dq_flush_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        fifo_en = 1'b0;
  logic        dq_write = 1'b0;
  logic        fifo_not_empty = 1'b0;
  logic        flush_req;
  logic        cfg_illegal;

  int  cyc = 0;
  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  int  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dq_flush_timer u_dq_flush_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .fifo_en(fifo_en), .dq_write(dq_write),
    .fifo_not_empty(fifo_not_empty), .flush_req(flush_req), .cfg_illegal(cfg_illegal)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Interval length in cycles, worked out from the interval value.
  function automatic int span(input int ival);
    return ival * 256;
  endfunction

  task automatic expect_flush(input int at, input string req);
    exp_q.push_back(at);
    tag_q.push_back(req);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_ival(input logic [15:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Monitor: pop the expected cycle when it is due; a flush at any other time fails.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && cyc == exp_q[0]) begin
        check(flush_req == 1'b1, tag_q[0], "flush at due cycle", int'(flush_req), 1);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end else if (flush_req) begin
        check(1'b0, (tag_q.size() > 0) ? tag_q[0] : "R3", "unexpected flush at cycle", cyc,
              (exp_q.size() > 0) ? exp_q[0] : -1);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int e;
    int x;
    int k2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rd_data == 16'h0, "R1", "reset interval", int'(cfg_rd_data), 0);
    check(flush_req == 1'b0, "R5", "reset flush", int'(flush_req), 0);
    check(cfg_illegal == 1'b0, "R6", "reset illegal flag", int'(cfg_illegal), 0);

    // R6: enable with interval 0 sets the flag and never flushes
    fifo_not_empty = 1'b1;
    fifo_en = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_illegal == 1'b1, "R6", "illegal flag set", int'(cfg_illegal), 1);
    wait_until(cyc + 700);
    fifo_en = 1'b0;
    @(negedge clk);
    check(cfg_illegal == 1'b1, "R6", "illegal flag sticky", int'(cfg_illegal), 1);

    write_ival(16'd2);
    check(cfg_rd_data == 16'd2, "R1", "readback", int'(cfg_rd_data), 2);

    // R2/R5: periodic flushes with a non-empty FIFO
    fifo_en = 1'b1;
    k = cyc + 1;
    expect_flush(k + span(2), "R2");
    expect_flush(k + 2 * span(2), "R5");
    wait_until(k + 2 * span(2) + 10);

    // R4: expiry while empty reloads silently
    fifo_not_empty = 1'b0;
    wait_until(k + 3 * span(2));
    fifo_not_empty = 1'b1;
    expect_flush(k + 4 * span(2), "R4");
    wait_until(k + 4 * span(2) + 100);

    // R7: strobe restarts the interval, and wins on the expiry edge
    dq_write = 1'b1;
    e = cyc + 1;
    @(negedge clk);
    dq_write = 1'b0;
    x = e + span(2);
    wait_until(x - 1);
    dq_write = 1'b1;
    @(negedge clk);
    dq_write = 1'b0;
    expect_flush(x + span(2), "R7");

    // R8: new interval value applies from the next reload
    wait_until(x + 20);
    write_ival(16'd1);
    check(cfg_rd_data == 16'd1, "R1", "readback after rewrite", int'(cfg_rd_data), 1);
    expect_flush(x + span(2) + span(1), "R8");
    wait_until(x + span(2) + span(1) + 50);

    // R3: disabled means silent; re-enable starts a full interval
    fifo_en = 1'b0;
    wait_until(cyc + 700);
    fifo_en = 1'b1;
    k2 = cyc + 1;
    expect_flush(k2 + span(1), "R3");
    wait_until(k2 + span(1) + 40);
    fifo_en = 1'b0;
    repeat (10) @(negedge clk);

    check(exp_q.size() == 0, "R2", "pending expected flushes", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule